// File: doc/BRIEF.md
# Sequential Radix-16 Significand Multiplier

This block is the front half of a double-precision multiply. It takes two 64-bit binary64 operands and splits each into its sign, exponent and fraction. A normal operand gets its hidden bit back. A subnormal operand is normalized so that its leading one sits in the hidden position, and the exponent is lowered by one for each place it moved. The block forms the product sign and a signed, unrounded result exponent.

The two 53-bit significands are then multiplied by a shift-and-add loop. The loop consumes four multiplier bits per clock, adding up to four shifted copies of the multiplicand into an accumulator. Every bit that falls off the bottom of the accumulator is folded into a sticky flag.

After the last step the product is normalized to a 53-bit significand with its leading one at the top. A guard bit and a sticky bit come with it, and both go to a separate rounding stage. A zero operand skips the loop and returns a signed zero one cycle after start. NaN, infinity, rounding and exception flags are handled elsewhere.

Top module: `fpm_iter_core`

## Requirements
- R1: `res_sign` is the XOR of bit 63 of both operands, including when the result is zero.
- R2: For nonzero operands, `res_exp` equals ea + eb − 1023, plus 1 when the significand product is 2 or more. Here ea and eb are the effective exponents defined in R3.
- R3: An operand with a nonzero exponent field (bits 62:52) has significand {1, fraction} and effective exponent equal to the field. An operand with a zero field and a nonzero fraction has effective exponent −k, where k is the count of leading zeros of the 52-bit fraction, and its significand is the fraction shifted left k+1 places.
- R4: If either operand has bits 62:0 all zero, then `res_sig`, `res_guard`, `res_sticky` and `res_exp` are all zero. `done` is asserted in the cycle after the cycle in which start was sampled, and `busy` never rises.
- R5: For nonzero operands, bit 52 of `res_sig` is set.
- R6: `res_sig` holds the top 53 bits of the exact 106-bit significand product counted from its leading one. `res_guard` is the next bit below. `res_sticky` is the OR of all remaining lower bits.
- R7: With nonzero operands, `busy` is high for exactly 14 cycles. `done` is asserted 15 cycles after the cycle in which `start` was sampled, and it appears in the cycle `busy` falls.
- R8: After reset, `busy` and `done` are low. `done` is a one-cycle pulse, and all result outputs hold their values until the next `done`.
- R9: A `start` that arrives while `busy` is high is ignored. The running operation completes with its own operands, and no further result follows.
- R10: `res_exp` is a 14-bit two's-complement value that represents results below 1 and at or above 2047 without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a multiply |
| op_a | input | 64 | First operand, binary64 |
| op_b | input | 64 | Second operand, binary64 |
| busy | output | 1 | Loop iterations in progress |
| done | output | 1 | One-cycle pulse; results valid this cycle |
| res_sign | output | 1 | Product sign |
| res_exp | output | 14 | Unrounded exponent, two's complement, biased by 1023 |
| res_sig | output | 53 | Normalized product significand |
| res_guard | output | 1 | First bit below the significand |
| res_sticky | output | 1 | OR of all bits below the guard bit |

## Verification
A multiply with both operands nonzero raises `busy` one cycle after `start` is sampled and returns its result 15 cycles after that sample. A zero operand returns its result after one cycle. The bench drives inputs on the falling edge and counts falling edges until `done`, so each latency check compares that count directly with 1 or 15. Result values are compared at the same falling edge, and then again a few cycles later to confirm they hold. For the ignored-start case, the bench keeps watching for 20 cycles after the result to confirm that neither `done` nor `busy` rises.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int unsigned DEF_FRAC_W    = 52;
  localparam int unsigned DEF_EXP_W     = 11;
  localparam int unsigned DEF_DIGIT_W   = 4;
  localparam int unsigned DEF_GUARD_PAD = 7;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fpm_state_e;

  // number of multiplier digits needed to cover the significand
  function automatic int unsigned digit_count(int unsigned sig_w, int unsigned digit_w);
    return (sig_w + digit_w - 1) / digit_w;
  endfunction
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack #(
  parameter int unsigned FRAC_W = 52,
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned XW     = 14
) (
  input  logic [FRAC_W+EXP_W:0]  op_i,
  output logic                   sign_o,
  output logic                   zero_o,
  output logic [FRAC_W:0]        sig_o,
  output logic signed [XW-1:0]   exp_o
);
  localparam int unsigned LZ_W = $clog2(FRAC_W + 1);

  logic [EXP_W-1:0]  efield;
  logic [FRAC_W-1:0] frac;
  logic [LZ_W-1:0]   lead_zeros;

  assign sign_o = op_i[FRAC_W+EXP_W];
  assign efield = op_i[FRAC_W+EXP_W-1:FRAC_W];
  assign frac   = op_i[FRAC_W-1:0];
  assign zero_o = (efield == '0) && (frac == '0);

  // leading-zero count: the highest set bit wins
  always_comb begin
    lead_zeros = '0;
    for (int i = 0; i < FRAC_W; i++) begin
      if (frac[i]) lead_zeros = LZ_W'(FRAC_W - 1 - i);
    end
  end

  always_comb begin
    if (efield != '0) begin
      sig_o = {1'b1, frac};
      exp_o = $signed({{(XW-EXP_W){1'b0}}, efield});
    end else begin
      sig_o = {frac, 1'b0} << lead_zeros;
      exp_o = -$signed({{(XW-LZ_W){1'b0}}, lead_zeros});
    end
  end
endmodule

// File: rtl/fpm_digit_step.sv
module fpm_digit_step #(
  parameter int unsigned CAND_W  = 60,
  parameter int unsigned DIGIT_W = 4,
  parameter int unsigned ACC_W   = 64
) (
  input  logic [ACC_W-1:0]   acc_i,
  input  logic [CAND_W-1:0]  cand_i,
  input  logic [DIGIT_W-1:0] digit_i,
  output logic [ACC_W-1:0]   acc_o,
  output logic               drop_o
);
  logic [ACC_W-1:0] term [DIGIT_W];

  generate
    for (genvar j = 0; j < DIGIT_W; j++) begin : g_term
      assign term[j] = digit_i[j] ? (ACC_W'(cand_i) << j) : '0;
    end
  endgenerate

  always_comb begin
    acc_o = acc_i >> DIGIT_W;
    for (int j = 0; j < DIGIT_W; j++) acc_o = acc_o + term[j];
  end

  assign drop_o = |acc_i[DIGIT_W-1:0];
endmodule

// File: rtl/fpm_post_norm.sv
module fpm_post_norm #(
  parameter int unsigned SIG_W = 53,
  parameter int unsigned TOP   = 60,
  parameter int unsigned XW    = 14
) (
  input  logic [TOP:0]          acc_i,
  input  logic                  sticky_i,
  input  logic signed [XW-1:0]  exp_i,
  output logic [SIG_W-1:0]      sig_o,
  output logic                  guard_o,
  output logic                  sticky_o,
  output logic signed [XW-1:0]  exp_o,
  output logic                  carry_o
);
  logic [TOP:0] aligned;

  assign carry_o  = acc_i[TOP];
  assign aligned  = carry_o ? acc_i : (acc_i << 1);
  assign sig_o    = aligned[TOP -: SIG_W];
  assign guard_o  = aligned[TOP-SIG_W];
  assign sticky_o = sticky_i | (|aligned[TOP-SIG_W-1:0]);
  assign exp_o    = exp_i + (carry_o ? XW'(1) : XW'(0));
endmodule

// File: rtl/fpm_iter_core.sv
module fpm_iter_core
  import fpm_pkg::*;
#(
  parameter int unsigned FRAC_W    = DEF_FRAC_W,
  parameter int unsigned EXP_W     = DEF_EXP_W,
  parameter int unsigned DIGIT_W   = DEF_DIGIT_W,
  parameter int unsigned GUARD_PAD = DEF_GUARD_PAD
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [FRAC_W+EXP_W:0]   op_a,
  input  logic [FRAC_W+EXP_W:0]   op_b,
  output logic                    busy,
  output logic                    done,
  output logic                    res_sign,
  output logic [EXP_W+2:0]        res_exp,
  output logic [FRAC_W:0]         res_sig,
  output logic                    res_guard,
  output logic                    res_sticky
);
  localparam int unsigned SIG_W  = FRAC_W + 1;
  localparam int unsigned XW     = EXP_W + 3;
  localparam int unsigned ITER   = digit_count(SIG_W, DIGIT_W);
  localparam int unsigned MPL_W  = ITER * DIGIT_W;
  localparam int unsigned CAND_W = SIG_W + GUARD_PAD;
  localparam int unsigned ACC_W  = CAND_W + DIGIT_W;
  localparam int unsigned SHR    = DIGIT_W * (ITER - 1);
  localparam int unsigned TOP    = 2 * SIG_W - 1 + GUARD_PAD - SHR;
  localparam int unsigned CNT_W  = $clog2(ITER);
  localparam logic signed [XW-1:0] BIAS = XW'((1 << (EXP_W - 1)) - 1);

  logic [FRAC_W+EXP_W:0]  ops    [2];
  logic                   u_sign [2];
  logic                   u_zero [2];
  logic [SIG_W-1:0]       u_sig  [2];
  logic signed [XW-1:0]   u_exp  [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  generate
    for (genvar k = 0; k < 2; k++) begin : g_unpack
      fpm_unpack #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .XW(XW)) i_unpack (
        .op_i(ops[k]), .sign_o(u_sign[k]), .zero_o(u_zero[k]),
        .sig_o(u_sig[k]), .exp_o(u_exp[k])
      );
    end
  endgenerate

  fpm_state_e           state;
  logic [ACC_W-1:0]     acc;
  logic [CAND_W-1:0]    cand;
  logic [MPL_W-1:0]     mplier;
  logic [CNT_W-1:0]     cnt;
  logic                 sticky_acc;
  logic signed [XW-1:0] exp_r;
  logic                 sign_r;

  // named events for the checker
  logic accept, zero_hit, step_last;
  logic prod_sign;
  logic signed [XW-1:0] exp_start;

  assign accept    = start && (state == ST_IDLE);
  assign zero_hit  = accept && (u_zero[0] || u_zero[1]);
  assign step_last = (state == ST_RUN) && (cnt == CNT_W'(ITER - 1));
  assign prod_sign = u_sign[0] ^ u_sign[1];
  assign exp_start = u_exp[0] + u_exp[1] - BIAS;
  assign busy      = (state == ST_RUN);

  logic [ACC_W-1:0] step_acc;
  logic             step_drop;

  fpm_digit_step #(.CAND_W(CAND_W), .DIGIT_W(DIGIT_W), .ACC_W(ACC_W)) i_step (
    .acc_i(acc), .cand_i(cand), .digit_i(mplier[DIGIT_W-1:0]),
    .acc_o(step_acc), .drop_o(step_drop)
  );

  logic [SIG_W-1:0]     pn_sig;
  logic                 pn_guard, pn_sticky, pn_carry;
  logic signed [XW-1:0] pn_exp;

  fpm_post_norm #(.SIG_W(SIG_W), .TOP(TOP), .XW(XW)) i_post (
    .acc_i(step_acc[TOP:0]), .sticky_i(sticky_acc | step_drop), .exp_i(exp_r),
    .sig_o(pn_sig), .guard_o(pn_guard), .sticky_o(pn_sticky),
    .exp_o(pn_exp), .carry_o(pn_carry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      acc        <= '0;
      cand       <= '0;
      mplier     <= '0;
      cnt        <= '0;
      sticky_acc <= 1'b0;
      exp_r      <= '0;
      sign_r     <= 1'b0;
      done       <= 1'b0;
      res_sign   <= 1'b0;
      res_exp    <= '0;
      res_sig    <= '0;
      res_guard  <= 1'b0;
      res_sticky <= 1'b0;
    end else begin
      done <= 1'b0;
      if (zero_hit) begin
        res_sign   <= prod_sign;
        res_exp    <= '0;
        res_sig    <= '0;
        res_guard  <= 1'b0;
        res_sticky <= 1'b0;
        done       <= 1'b1;
      end else if (accept) begin
        acc        <= '0;
        cand       <= {u_sig[1], {GUARD_PAD{1'b0}}};
        mplier     <= MPL_W'(u_sig[0]);
        cnt        <= '0;
        sticky_acc <= 1'b0;
        exp_r      <= exp_start;
        sign_r     <= prod_sign;
        state      <= ST_RUN;
      end else if (state == ST_RUN) begin
        acc        <= step_acc;
        sticky_acc <= sticky_acc | step_drop;
        mplier     <= mplier >> DIGIT_W;
        cnt        <= cnt + CNT_W'(1);
        if (step_last) begin
          state      <= ST_IDLE;
          done       <= 1'b1;
          res_sign   <= sign_r;
          res_exp    <= pn_exp;
          res_sig    <= pn_sig;
          res_guard  <= pn_guard;
          res_sticky <= pn_sticky;
        end
      end
    end
  end
endmodule

module fpm_iter_core_chk #(
  parameter int unsigned FRAC_W  = 52,
  parameter int unsigned DIGIT_W = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          res_sign,
  input logic [FRAC_W:0] res_sig,
  input logic          res_guard,
  input logic          res_sticky,
  input logic          step_last
);
  localparam int unsigned ITER = fpm_pkg::digit_count(FRAC_W + 1, DIGIT_W);
  localparam int unsigned RL_W = $clog2(ITER + 2) + 1;

  logic [RL_W-1:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + RL_W'(1);
    else           run_len <= '0;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_sig) && $stable(res_sign) && $stable(res_guard) && $stable(res_sticky)));
  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  // R7
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == RL_W'(ITER)));
  // R5
  lead_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_sig[FRAC_W] || (res_sig == '0 && !res_guard && !res_sticky)));
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_last) |=> busy);
endmodule

bind fpm_iter_core fpm_iter_core_chk #(.FRAC_W(FRAC_W), .DIGIT_W(DIGIT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .res_sign(res_sign),
  .res_sig(res_sig), .res_guard(res_guard), .res_sticky(res_sticky),
  .step_last(step_last)
);

// File: tb/test_fpm_iter_core.sv
`timescale 1ns/1ps
module test_fpm_iter_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic busy, done, res_sign, res_guard, res_sticky;
  logic [13:0] res_exp;
  logic [52:0] res_sig;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fpm_iter_core i_fpm_iter_core (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .res_sign(res_sign), .res_exp(res_exp),
    .res_sig(res_sig), .res_guard(res_guard), .res_sticky(res_sticky)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // own restatement of the arithmetic: unpack by shifting, exact wide product
  function automatic void expect_mul(input logic [63:0] a, input logic [63:0] b,
      output bit s, output int e, output logic [52:0] sig, output bit g, output bit st,
      output bit is_zero);
    logic [52:0] m [2];
    int x [2];
    logic [63:0] v [2];
    logic [105:0] p;
    v[0] = a; v[1] = b;
    s = a[63] ^ b[63];
    is_zero = (a[62:0] == 0) || (b[62:0] == 0);
    if (is_zero) begin
      e = 0; sig = '0; g = 0; st = 0;
      return;
    end
    for (int k = 0; k < 2; k++) begin
      if (v[k][62:52] != 0) begin
        m[k] = {1'b1, v[k][51:0]};
        x[k] = int'(v[k][62:52]);
      end else begin
        m[k] = {1'b0, v[k][51:0]};
        x[k] = 1;
        while (!m[k][52]) begin
          m[k] = m[k] << 1;
          x[k] = x[k] - 1;
        end
      end
    end
    p = {53'b0, m[0]} * {53'b0, m[1]};
    e = x[0] + x[1] - 1023;
    if (p[105]) begin
      sig = p[105:53]; g = p[52]; st = |p[51:0]; e = e + 1;
    end else begin
      sig = p[104:52]; g = p[51]; st = |p[50:0];
    end
  endfunction

  task automatic compare_out(input logic [63:0] a, input logic [63:0] b, input string tag);
    bit s, g, st, z;
    int e;
    logic [52:0] sig;
    expect_mul(a, b, s, e, sig, g, st, z);
    check("R1", {tag, " sign"}, longint'(res_sign), longint'(s));
    check(z ? "R4" : "R2/R10", {tag, " exp"}, longint'($signed(res_exp)), longint'(e));
    check(z ? "R4" : "R3/R5", {tag, " sig"}, longint'(res_sig), longint'(sig));
    check("R6", {tag, " guard"}, longint'(res_guard), longint'(g));
    check("R6", {tag, " sticky"}, longint'(res_sticky), longint'(st));
  endtask

  // drive one operation; optionally pulse a second start at cycle `intrude_at`
  task automatic do_op(input logic [63:0] a, input logic [63:0] b, input string tag,
                       input int intrude_at);
    bit s, g, st, z;
    int e, lat;
    bit busy_first;
    logic [52:0] sig;
    expect_mul(a, b, s, e, sig, g, st, z);
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    busy_first = busy;
    while (!done && lat < 40) begin
      if (lat == intrude_at) begin
        op_a = 64'h4000_0000_0000_0000; op_b = 64'hC008_0000_0000_0000; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    if (z) begin
      check("R4", {tag, " latency"}, lat, 1);
      check("R4", {tag, " busy"}, longint'(busy_first), 0);
    end else begin
      check("R7", {tag, " latency"}, lat, 15);
      check("R7", {tag, " busy"}, longint'(busy_first), 1);
      check("R7", {tag, " busy at done"}, longint'(busy), 0);
    end
    compare_out(a, b, tag);
  endtask

  function automatic logic [63:0] rand_op();
    logic [63:0] r;
    logic [10:0] ex;
    r = {$urandom, $urandom};
    ex = ($urandom_range(0, 7) == 0) ? 11'd0 : 11'($urandom_range(1, 2046));
    if ($urandom_range(0, 24) == 0) r[51:0] = '0;
    return {r[63], ex, r[51:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8", "reset busy", longint'(busy), 0);
    check("R8", "reset done", longint'(done), 0);

    // R2 1.0 * 1.0
    do_op(64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, "one*one", 0);
    // R2 carry: 1.5 * 1.5
    do_op(64'h3FF8_0000_0000_0000, 64'hBFF8_0000_0000_0000, "1.5*-1.5", 0);
    // R3 R10 smallest subnormals: exponent far below 1
    do_op(64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001, "minsub^2", 0);
    check("R10", "minsub exp", longint'($signed(res_exp)), -1125);
    // R3 subnormal times normal
    do_op(64'h000F_FFFF_FFFF_FFFF, 64'h4010_0000_0000_0003, "sub*norm", 0);
    // R10 largest finite squared: exponent above 2046
    do_op(64'h7FEF_FFFF_FFFF_FFFF, 64'h7FEF_FFFF_FFFF_FFFF, "max^2", 0);
    check("R10", "max exp", longint'($signed(res_exp)), 3070);
    // R4 R1 signed zeros
    do_op(64'h0000_0000_0000_0000, 64'hC014_0000_0000_0000, "+0*-5", 0);
    check("R1", "zero sign", longint'(res_sign), 1);
    do_op(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "-0*-0", 0);

    // R8 outputs hold after done
    do_op(64'h4009_21FB_5444_2D18, 64'h4005_BF0A_8B14_5769, "pi*e", 0);
    repeat (3) @(negedge clk);
    compare_out(64'h4009_21FB_5444_2D18, 64'h4005_BF0A_8B14_5769, "R8 hold");
    check("R8", "done pulse", longint'(done), 0);

    // R9 start during busy is ignored
    do_op(64'h3FF5_5555_5555_5555, 64'h4022_3456_789A_BCDE, "R9 intrude", 5);
    begin
      int extra = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (done || busy) extra++;
      end
      check("R9", "activity after ignored start", extra, 0);
    end

    // random mix
    for (int n = 0; n < 80; n++) begin
      do_op(rand_op(), rand_op(), $sformatf("rnd%0d", n), 0);
    end

    finish_run();
  end
endmodule